// File: doc/BRIEF.md
# Load Data Byte-Lane Rotator

This block sits on the data path between a 32-bit memory bus and the register file. On a load it takes the word read from memory and steers its bytes according to the low two address bits. A word access to an address that is not word aligned comes back rotated, not faulted and not split into two accesses. A byte access returns the addressed byte zero-extended to 32 bits. Byte ordering is set by an endianness strap.

On a store the same data input carries the register value, which goes to the bus unchanged. A word store ignores the low address bits. A byte store copies its low byte onto all four lanes, so memory can take the lane it needs.

The result and its valid flag are registered: every accepted request produces one output one cycle later. Moving a half-word down into the low 16 bits, and sign-extending it, is left to a later shifter.

Top module: `ld_lane_rot`

## Requirements
- R1: After reset `out_vld` is 0 and `result` is 0.
- R2: `out_vld` equals the value `in_vld` had at the previous rising clock edge; a request sampled with `in_vld`=1 gives its `result` at the next edge.
- R3: Word load (`is_load`=1, `is_byte`=0) with `big_end`=0: result byte k (bits 8k+7..8k) is input byte (k+`addr_lo`) mod 4, which is a rotate right by 8·`addr_lo` bits. Offset 0 leaves the word unchanged.
- R4: Word load with `big_end`=1 (address byte j is held in bits 31-8j..24-8j): at offset 0 or 2 the addressed byte ends up in result bits 31..24, and at offset 1 or 3 it ends up in bits 15..8.
- R5: Big-endian word load at offset 0 or 2: the addressed half-word (address bytes a and a+1) appears in result bits 31..16, with byte a in the upper position.
- R6: Byte load (`is_load`=1, `is_byte`=1) with `big_end`=0: result = {24'b0, `din`[8·`addr_lo`+7 : 8·`addr_lo`]}.
- R7: Byte load with `big_end`=1: result = {24'b0, `din`[31-8·`addr_lo` : 24-8·`addr_lo`]}.
- R8: Word store (`is_load`=0, `is_byte`=0): result equals `din` bit for bit, whatever `addr_lo` and `big_end` are.
- R9: Byte store (`is_load`=0, `is_byte`=1): result is `din`[7:0] repeated on all four byte lanes, whatever `addr_lo` and `big_end` are.
- R10: In a cycle where `in_vld` is 0, `result` keeps its previous value and the data and control inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Request strobe |
| is_load | input | 1 | 1 = load from bus, 0 = store to bus |
| is_byte | input | 1 | 1 = byte access, 0 = word access |
| big_end | input | 1 | Endianness strap, 1 = big-endian |
| addr_lo | input | 2 | Address bits 1..0 |
| din | input | 32 | Bus read data (load) or register value (store) |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| result | output | 32 | Value for the register file (load) or for the bus (store) |

## Verification
The design holds one result register and one valid flag, so any bad internal state shows up at the ports on the cycle right after the request that caused it. A wrong rotate amount or lane choice puts bytes in the wrong positions of `result`. A lost or duplicated strobe shows up as an `out_vld` that does not match the delayed `in_vld`. A register that loads while idle changes `result` during a gap. Every request is therefore compared against an independently built byte model on the very next cycle, and every idle cycle is checked for a held result.

// File: rtl/ld_lane_rot.sv
module ld_lane_rot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          is_load,
  input  logic          is_byte,
  input  logic          big_end,
  input  logic [1:0]    addr_lo,
  input  logic [DW-1:0] din,
  output logic          out_vld,
  output logic [DW-1:0] result
);
  localparam int NB = DW / 8;

  logic [DW-1:0] rot_w;
  logic [DW-1:0] nxt;
  logic [7:0]    sel_b;
  logic [1:0]    lane;

  assign rot_w = (din >> (8 * addr_lo)) | (din << (DW - 8 * addr_lo));
  assign lane  = big_end ? (2'd3 - addr_lo) : addr_lo;
  assign sel_b = din[8*lane +: 8];

  always_comb begin
    case ({is_load, is_byte})
      2'b11:   nxt = {{(DW-8){1'b0}}, sel_b};
      2'b10:   nxt = (addr_lo == 2'd0) ? din : rot_w;
      2'b01:   nxt = {NB{din[7:0]}};
      default: nxt = din;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      result  <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) result <= nxt;
    end
  end

  a_r2_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld));

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_vld) |-> $stable(result));

  a_r8_word_store_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && !is_load && !is_byte) |-> result == $past(din));

  a_r9_byte_store_rep: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && !is_load && is_byte) |-> result == {NB{$past(din[7:0])}});

  a_r6_r7_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && is_load && is_byte) |-> result[DW-1:8] == '0);

  a_r3_r4_rot_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && is_load && !is_byte) |-> $countones(result) == $countones($past(din)));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (out_vld == 1'b0));
endmodule

// File: tb/sim_ld_lane_rot.sv
module sim_ld_lane_rot;
  logic clk = 0, rst_n = 0, in_vld = 0, is_load = 0, is_byte = 0, big_end = 0;
  logic [1:0] addr_lo = 0;
  logic [31:0] din = 0;
  logic out_vld;
  logic [31:0] result;
  int n_chk = 0, n_bad = 0;
  logic [31:0] last_exp = 0;

  always #5 clk = ~clk;

  ld_lane_rot u0 (.clk, .rst_n, .in_vld, .is_load, .is_byte, .big_end,
                  .addr_lo, .din, .out_vld, .result);

  function automatic logic [7:0] byte_of(logic [31:0] w, int k);
    return w[8*k +: 8];
  endfunction

  function automatic logic [31:0] model(logic ld, logic by, logic be, logic [1:0] a, logic [31:0] d);
    logic [31:0] r;
    r = 0;
    if (ld && !by) begin
      for (int k = 0; k < 4; k++) r[8*k +: 8] = byte_of(d, (k + a) % 4);
    end else if (ld && by) begin
      r = {24'b0, be ? byte_of(d, 3 - a) : byte_of(d, a)};
    end else if (by) begin
      for (int k = 0; k < 4; k++) r[8*k +: 8] = d[7:0];
    end else r = d;
    return r;
  endfunction

  function automatic string tag(logic ld, logic by, logic be);
    if (ld && !by) return be ? "R4" : "R3";
    if (ld && by)  return be ? "R7" : "R6";
    if (by) return "R9";
    return "R8";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(logic ld, logic by, logic be, logic [1:0] a, logic [31:0] d);
    in_vld = 1; is_load = ld; is_byte = by; big_end = be; addr_lo = a; din = d;
    @(negedge clk);
    last_exp = model(ld, by, be, a, d);
    check("R2", {31'b0, out_vld}, 32'd1);
    check(tag(ld, by, be), result, last_exp);
  endtask

  task automatic idle(logic [31:0] d);
    in_vld = 0; is_load = d[0]; is_byte = d[1]; big_end = d[2]; addr_lo = d[4:3]; din = d;
    @(negedge clk);
    check("R2", {31'b0, out_vld}, 32'd0);
    check("R10", result, last_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1", {31'b0, out_vld}, 32'd0);
    check("R1", result, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R4 and R5: big-endian word loads of 11223344 (address byte 0 = 8'h11)
    xfer(1, 0, 1, 2'd0, 32'h11223344);
    check("R4", {24'b0, result[31:24]}, 32'h11);
    check("R5", {16'b0, result[31:16]}, 32'h1122);
    xfer(1, 0, 1, 2'd1, 32'h11223344);
    check("R4", {24'b0, result[15:8]}, 32'h22);
    xfer(1, 0, 1, 2'd2, 32'h11223344);
    check("R4", {24'b0, result[31:24]}, 32'h33);
    check("R5", {16'b0, result[31:16]}, 32'h3344);
    xfer(1, 0, 1, 2'd3, 32'h11223344);
    check("R4", {24'b0, result[15:8]}, 32'h44);
    // R3: little-endian rotations
    xfer(1, 0, 0, 2'd0, 32'hA1B2C3D4);
    check("R3", result, 32'hA1B2C3D4);
    xfer(1, 0, 0, 2'd1, 32'hA1B2C3D4);
    check("R3", result, 32'hD4A1B2C3);
    xfer(1, 0, 0, 2'd3, 32'hA1B2C3D4);
    check("R3", result, 32'hB2C3D4A1);
    // R6, R7 byte loads with a high bit set
    xfer(1, 1, 0, 2'd3, 32'hF0000000);
    check("R6", result, 32'h000000F0);
    xfer(1, 1, 1, 2'd0, 32'hF0000000);
    check("R7", result, 32'h000000F0);
    // R8 word store at misaligned offset, R9 byte store
    xfer(0, 0, 1, 2'd3, 32'h80000001);
    check("R8", result, 32'h80000001);
    xfer(0, 1, 0, 2'd2, 32'h123456AB);
    check("R9", result, 32'hABABABAB);
    idle(32'hFFFFFFFF);
    idle(32'h00000000);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:29] == 3'd0) idle($urandom);
      else xfer(r[0], r[1], r[2], r[4:3], $urandom);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule